// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block steps a shadow-memory device through its two transfers between the volatile array and the nonvolatile cells. A save first wipes the old nonvolatile contents and then writes the new ones. A restore first empties the volatile array and then loads the nonvolatile contents into it. Single-cycle request pulses from an upstream command detector start each operation. A synchronised supply-good flag gates saves, and a rising edge on that flag starts a power-up restore without any request.

While an operation runs, a busy flag stays high. The surrounding bus logic uses it to ignore all accesses and to float the data pins. Each phase enable drives the matching array control directly. Operation lengths are parameters counted in clock cycles. Each operation is split into two phases: the first phase takes the integer half of the total and the second phase takes the rest.

A save stops when the supply flag drops. A restore does not stop for that reason. A one-cycle completion pulse marks every operation that finishes normally. A separate one-cycle pulse marks a save that was cut short.

Top module: `nvx_ctrl`

## Requirements
- R1: During and right after synchronous reset, busy, all four phase enables, op_done and store_aborted are low.
- R2: When vcc_ok is high and was low in the previous cycle (this includes the first cycle after reset) while idle, a power-up restore starts. clear_en is high for PWRUP_CYC/2 cycles starting the next cycle, then xfer_en is high for the remaining cycles.
- R3: A store_req sampled while idle with vcc_ok high gives erase_en for STORE_CYC/2 cycles starting the next cycle, then program_en for STORE_CYC - STORE_CYC/2 cycles.
- R4: A recall_req sampled while idle gives clear_en for RECALL_CYC/2 cycles starting the next cycle, then xfer_en for the remaining cycles.
- R5: At most one phase enable is high in any cycle, and busy is high exactly when one of them is.
- R6: While busy, store_req, recall_req and a rising vcc_ok are discarded. The running operation keeps its phases and lengths, and no operation follows it.
- R7: A store_req sampled while vcc_ok is low is rejected: busy stays low and no operation starts.
- R8: If vcc_ok is low at a clock edge during either save phase, the next cycle has busy and all phase enables low and store_aborted high for one cycle, and op_done stays low.
- R9: A restore keeps running to completion when vcc_ok falls during it.
- R10: If store_req and recall_req are sampled together while idle, the restore runs.
- R11: op_done is high for exactly one cycle: the first idle cycle after the last phase cycle of an operation that was not aborted.
- R12: A rising vcc_ok while idle takes priority over a store_req sampled in the same cycle, and the power-up restore lengths apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Synchronised flag, high while the supply is above the switch level |
| store_req | input | 1 | One-cycle save request |
| recall_req | input | 1 | One-cycle restore request |
| busy | output | 1 | High while an operation runs; bus I/O is disabled and the data pins are floated |
| erase_en | output | 1 | Save phase one: wipe the nonvolatile cells |
| program_en | output | 1 | Save phase two: write the nonvolatile cells |
| clear_en | output | 1 | Restore phase one: empty the volatile array |
| xfer_en | output | 1 | Restore phase two: copy the nonvolatile data into the volatile array |
| op_done | output | 1 | One-cycle pulse when an operation completes |
| store_aborted | output | 1 | One-cycle pulse when a save is cut short by supply loss |

## Verification
The bench builds the block with STORE_CYC=9, RECALL_CYC=12 and PWRUP_CYC=7. With an odd save total the unequal 4/5 split is exercised. With a different power-up total the bench can tell which restore length was chosen, which matters for the priority rule of R12. These short lengths let the bench drop the supply in either save phase, send requests and supply edges in the middle of an operation, and run every operation to completion within a few dozen cycles.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ERASE = 3'd1,
    S_PROG  = 3'd2,
    S_CLEAR = 3'd3,
    S_XFER  = 3'd4
  } nvx_state_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2,
    OP_PWRUP  = 2'd3
  } nvx_op_e;

endpackage

// File: rtl/nvx_req_arb.sv
module nvx_req_arb
  import nvx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    vcc_ok,
  input  logic    store_req,
  input  logic    recall_req,
  input  logic    idle,
  output nvx_op_e start_op
);

  logic vcc_q;

  always_ff @(posedge clk) begin
    if (rst) vcc_q <= 1'b0;
    else     vcc_q <= vcc_ok;
  end

  logic vcc_rise;
  assign vcc_rise = vcc_ok & ~vcc_q;

  // Priority: supply rise, then restore request, then save request.
  always_comb begin
    start_op = OP_NONE;
    if (idle) begin
      if (vcc_rise)                 start_op = OP_PWRUP;
      else if (recall_req)          start_op = OP_RECALL;
      else if (store_req && vcc_ok) start_op = OP_STORE;
    end
  end

  // R7: a save never starts without supply
  a_r7_store_needs_supply: assert property (@(posedge clk) disable iff (rst)
    (start_op == OP_STORE) |-> vcc_ok);

  // R6: nothing starts while an operation is running
  a_r6_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
    !idle |-> (start_op == OP_NONE));

  // R10: a restore request is never passed over for a save
  a_r10_recall_wins: assert property (@(posedge clk) disable iff (rst)
    (idle && recall_req) |-> (start_op != OP_STORE));

endmodule

// File: rtl/nvx_phase_timer.sv
module nvx_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));

  // A loaded phase always reaches its final cycle through a decrement
  a_r3_timer_counts_down: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt > CNT_W'(1)) |=> !last || ($past(cnt) == CNT_W'(2)));

endmodule

// File: rtl/nvx_ctrl.sv
module nvx_ctrl
  import nvx_pkg::*;
#(
  parameter int STORE_CYC  = 500000,
  parameter int RECALL_CYC = 1000000,
  parameter int PWRUP_CYC  = 32500
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_ok,
  input  logic store_req,
  input  logic recall_req,
  output logic busy,
  output logic erase_en,
  output logic program_en,
  output logic clear_en,
  output logic xfer_en,
  output logic op_done,
  output logic store_aborted
);

  localparam int ST_P1 = STORE_CYC / 2;
  localparam int ST_P2 = STORE_CYC - ST_P1;
  localparam int RC_P1 = RECALL_CYC / 2;
  localparam int RC_P2 = RECALL_CYC - RC_P1;
  localparam int PU_P1 = PWRUP_CYC / 2;
  localparam int PU_P2 = PWRUP_CYC - PU_P1;
  localparam int MAX_A = (ST_P2 > RC_P2) ? ST_P2 : RC_P2;
  localparam int MAX_P = (MAX_A > PU_P2) ? MAX_A : PU_P2;
  localparam int CNT_W = $clog2(MAX_P + 1);

  nvx_state_e       state, state_n;
  nvx_op_e          start_op;
  logic             pwr_q, pwr_n;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             last;
  logic             done_n, abort_n;
  logic             idle;

  assign idle = (state == S_IDLE);

  nvx_req_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .vcc_ok    (vcc_ok),
    .store_req (store_req),
    .recall_req(recall_req),
    .idle      (idle),
    .start_op  (start_op)
  );

  nvx_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(load_val),
    .last    (last)
  );

  always_comb begin
    state_n  = state;
    pwr_n    = pwr_q;
    load     = 1'b0;
    load_val = '0;
    done_n   = 1'b0;
    abort_n  = 1'b0;
    unique case (state)
      S_IDLE: begin
        unique case (start_op)
          OP_STORE: begin
            state_n = S_ERASE; load = 1'b1; load_val = CNT_W'(ST_P1);
          end
          OP_RECALL: begin
            state_n = S_CLEAR; pwr_n = 1'b0; load = 1'b1; load_val = CNT_W'(RC_P1);
          end
          OP_PWRUP: begin
            state_n = S_CLEAR; pwr_n = 1'b1; load = 1'b1; load_val = CNT_W'(PU_P1);
          end
          default: ;
        endcase
      end
      S_ERASE, S_PROG: begin
        if (!vcc_ok) begin
          state_n = S_IDLE;
          abort_n = 1'b1;
        end else if (last) begin
          if (state == S_ERASE) begin
            state_n = S_PROG; load = 1'b1; load_val = CNT_W'(ST_P2);
          end else begin
            state_n = S_IDLE; done_n = 1'b1;
          end
        end
      end
      S_CLEAR: begin
        if (last) begin
          state_n  = S_XFER;
          load     = 1'b1;
          load_val = pwr_q ? CNT_W'(PU_P2) : CNT_W'(RC_P2);
        end
      end
      S_XFER: begin
        if (last) begin
          state_n = S_IDLE; done_n = 1'b1;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      pwr_q         <= 1'b0;
      op_done       <= 1'b0;
      store_aborted <= 1'b0;
    end else begin
      state         <= state_n;
      pwr_q         <= pwr_n;
      op_done       <= done_n;
      store_aborted <= abort_n;
    end
  end

  assign busy       = !idle;
  assign erase_en   = (state == S_ERASE);
  assign program_en = (state == S_PROG);
  assign clear_en   = (state == S_CLEAR);
  assign xfer_en    = (state == S_XFER);

  // R5: one phase at a time, busy tracks the phases
  a_r5_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({erase_en, program_en, clear_en, xfer_en}));
  a_r5_busy_phase: assert property (@(posedge clk) disable iff (rst)
    busy == (erase_en | program_en | clear_en | xfer_en));

  // R8: supply loss during a save ends it in the next cycle
  a_r8_store_abort: assert property (@(posedge clk) disable iff (rst)
    ((erase_en || program_en) && !vcc_ok) |=> (!busy && store_aborted && !op_done));

  // R3: erase hands over to program, never to a restore phase
  a_r3_erase_then_prog: assert property (@(posedge clk) disable iff (rst)
    (erase_en && vcc_ok) |=> (erase_en || program_en));

  // R9: restore phases continue regardless of supply
  a_r9_recall_holds: assert property (@(posedge clk) disable iff (rst)
    clear_en |=> (clear_en || xfer_en));

  // R7: save request without supply starts nothing
  a_r7_reject: assert property (@(posedge clk) disable iff (rst)
    (!busy && store_req && !recall_req && !vcc_ok) |=> !busy);

  // R11: done follows a final phase and lasts one cycle
  a_r11_done_after_final: assert property (@(posedge clk) disable iff (rst)
    op_done |-> (!busy && ($past(program_en) || $past(xfer_en))));
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);

endmodule

// File: tb/nvx_ctrl_tb.sv
module nvx_ctrl_tb;

  localparam int ST  = 9;
  localparam int RC  = 12;
  localparam int PU  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_ok = 1'b0;
  logic store_req = 1'b0;
  logic recall_req = 1'b0;
  logic busy, erase_en, program_en, clear_en, xfer_en, op_done, store_aborted;

  always #5 clk = ~clk;

  nvx_ctrl #(.STORE_CYC(ST), .RECALL_CYC(RC), .PWRUP_CYC(PU)) u_dut (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .store_req(store_req),
    .recall_req(recall_req), .busy(busy), .erase_en(erase_en),
    .program_en(program_en), .clear_en(clear_en), .xfer_en(xfer_en),
    .op_done(op_done), .store_aborted(store_aborted)
  );

  typedef struct {
    int    er, pg, cl, xf;
    bit    dn, ab;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic expect_op(input int er, input int pg, input int cl, input int xf,
                           input bit dn, input bit ab, input string tag);
    exp_t e;
    e.er = er; e.pg = pg; e.cl = cl; e.xf = xf; e.dn = dn; e.ab = ab; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic pulse(input bit s, input bit r);
    @(negedge clk);
    store_req = s; recall_req = r;
    @(negedge clk);
    store_req = 1'b0; recall_req = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: measures each operation and compares with the scoreboard
  int c_er, c_pg, c_cl, c_xf;
  bit prev_busy, prev_done, order_bad;

  always @(negedge clk) begin
    if (rst) begin
      c_er = 0; c_pg = 0; c_cl = 0; c_xf = 0;
      prev_busy = 1'b0; prev_done = 1'b0; order_bad = 1'b0;
    end else begin
      // R5: phase exclusivity and busy consistency every cycle
      check($countones({erase_en, program_en, clear_en, xfer_en}) <= 1, "R5 onehot",
            $countones({erase_en, program_en, clear_en, xfer_en}), 1);
      check(busy == (erase_en | program_en | clear_en | xfer_en), "R5 busy",
            busy, erase_en | program_en | clear_en | xfer_en);
      // R11: done never lasts two cycles
      if (prev_done) check(!op_done, "R11 done width", op_done, 0);
      if (busy) begin
        if (erase_en && c_pg != 0) order_bad = 1'b1;
        if (clear_en && c_xf != 0) order_bad = 1'b1;
        c_er += int'(erase_en); c_pg += int'(program_en);
        c_cl += int'(clear_en); c_xf += int'(xfer_en);
      end else if (prev_busy) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected operation", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(c_er == e.er, {e.tag, " erase cycles"}, c_er, e.er);
          check(c_pg == e.pg, {e.tag, " program cycles"}, c_pg, e.pg);
          check(c_cl == e.cl, {e.tag, " clear cycles"}, c_cl, e.cl);
          check(c_xf == e.xf, {e.tag, " transfer cycles"}, c_xf, e.xf);
          check(op_done == e.dn, {e.tag, " op_done"}, op_done, e.dn);
          check(store_aborted == e.ab, {e.tag, " store_aborted"}, store_aborted, e.ab);
          check(!order_bad, {e.tag, " phase order"}, order_bad, 0);
        end
        c_er = 0; c_pg = 0; c_cl = 0; c_xf = 0; order_bad = 1'b0;
      end else begin
        check(!op_done && !store_aborted, "R11/R8 stray pulse",
              {op_done, store_aborted}, 0);
      end
      prev_busy = busy;
      prev_done = op_done;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check({busy, erase_en, program_en, clear_en, xfer_en, op_done, store_aborted} == 7'b0,
          "R1 reset outputs", {busy, erase_en, program_en, clear_en, xfer_en, op_done, store_aborted}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy, "R1 idle after reset", busy, 0);

    // R7: save rejected without supply
    pulse(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      check(!busy && !erase_en, "R7 rejected store", busy, 0);
      @(negedge clk);
    end

    // R2: power-up restore on supply rise
    expect_op(0, 0, PU/2, PU - PU/2, 1, 0, "R2 power-up recall");
    vcc_ok = 1'b1;
    @(negedge clk);
    check(clear_en, "R2 clear starts next cycle", clear_en, 1);
    wait_cyc(PU + 3);

    // R3: save with supply
    expect_op(ST/2, ST - ST/2, 0, 0, 1, 0, "R3 store");
    pulse(1'b1, 1'b0);
    check(erase_en, "R3 erase starts next cycle", erase_en, 1);
    wait_cyc(ST + 3);

    // R4: software restore
    expect_op(0, 0, RC/2, RC - RC/2, 1, 0, "R4 recall");
    pulse(1'b0, 1'b1);
    wait_cyc(RC + 3);

    // R10: both requests together
    expect_op(0, 0, RC/2, RC - RC/2, 1, 0, "R10 simultaneous");
    pulse(1'b1, 1'b1);
    wait_cyc(RC + 3);

    // R6: requests during a save are discarded
    expect_op(ST/2, ST - ST/2, 0, 0, 1, 0, "R6 busy store");
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    wait_cyc(ST + 3);

    // R8: abort in erase phase
    expect_op(1, 0, 0, 0, 0, 1, "R8 abort in erase");
    pulse(1'b1, 1'b0);
    vcc_ok = 1'b0;
    @(negedge clk);
    check(!busy && store_aborted, "R8 abort next cycle", {busy, store_aborted}, 1);
    wait_cyc(3);
    expect_op(0, 0, PU/2, PU - PU/2, 1, 0, "R2 recall after abort");
    vcc_ok = 1'b1;
    wait_cyc(PU + 3);

    // R8: abort in program phase
    expect_op(ST/2, 2, 0, 0, 0, 1, "R8 abort in program");
    pulse(1'b1, 1'b0);
    wait_cyc(ST/2 + 1);
    vcc_ok = 1'b0;
    wait_cyc(4);
    expect_op(0, 0, PU/2, PU - PU/2, 1, 0, "R2 recall after abort 2");
    vcc_ok = 1'b1;
    wait_cyc(PU + 3);

    // R9: restore survives supply loss; rise while busy discarded (R6)
    expect_op(0, 0, RC/2, RC - RC/2, 1, 0, "R9 recall with supply dip");
    pulse(1'b0, 1'b1);
    wait_cyc(2);
    vcc_ok = 1'b0;
    wait_cyc(4);
    vcc_ok = 1'b1;
    wait_cyc(RC + 3);

    // R12: supply rise beats a save request in the same cycle
    vcc_ok = 1'b0;
    wait_cyc(3);
    expect_op(0, 0, PU/2, PU - PU/2, 1, 0, "R12 rise over store");
    @(negedge clk);
    vcc_ok = 1'b1;
    store_req = 1'b1;
    @(negedge clk);
    store_req = 1'b0;
    wait_cyc(PU + 4);

    check(exp_q.size() == 0, "R6 all expected operations seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule